// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is a single 32-bit register on a configuration bus. It holds a small field of reset cause flags in its top five bits, and software uses it to ask for a system reset. A read returns the stored flags with every other bit at zero. A write does three things in the same cycle. It clears the flags that software acknowledges by writing ones. It loads the two soft-request bits from the data. It raises a one-cycle reset request when one of those two bits is written as one.

The power-on cause flag is loaded only by the first system reset after a power-on indication. A flip-flop tracks whether that flag is still owed. A later system reset leaves the register as it was, so software can read why the reset happened. The two button inputs set their flags in any cycle, including cycles in which the system reset is high.

Top module: `rst_cause_reg`

## Requirements
- R1: Only bits 31:27 hold state. Bits 26:0 always read as zero, whatever data was written to them.
- R2: Bit 31 (power-on cause), bit 28 (button power-on) and bit 27 (button external reset) are write-one-to-clear. Writing a zero to one of these bits leaves it unchanged.
- R3: On every write, bit 30 (soft power-on) and bit 29 (soft external reset) take the written data bits, and a zero clears them.
- R4: A write with bit 30 or bit 29 set drives `sys_rst_req` high for exactly the next cycle. A write with both bits clear gives no pulse.
- R5: The first cycle with `rst` high after `pwr_on` loads the field with only bit 31 set, that is 0x80000000, plus any button input that is high in that same cycle.
- R6: A `rst` cycle after that first one, with no `pwr_on` between them, leaves the register unchanged, apart from button inputs that are high in that cycle.
- R7: `btn_por` high sets bit 28 and `btn_xir` high sets bit 27, in any cycle. When a write clears one of these bits in the same cycle, the set wins.
- R8: A write presented while `rst` is high has no effect on the register and gives no request pulse.
- R9: `pwr_on` alone does not change the register. It re-arms the block, so the next `rst` cycle reloads 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| pwr_on | input | 1 | Power-on indication, active high; re-arms the power-on cause capture |
| btn_por | input | 1 | Button power-on reset seen; sets bit 28 |
| btn_xir | input | 1 | Button external reset seen; sets bit 27 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register contents, bits 26:0 zero |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Two things can land on a status bit in the same cycle: a button setting it and a software write clearing it. The bench drives `btn_por` or `btn_xir` high in the same cycle as a write of ones to bits 28 and 27, and expects the button bit to stay set while the other written fields still take effect. A second overlap is a write that arrives while `rst` is high. There the bench expects the reset to take priority: the register does not change and no request pulse follows. These cases come after an exhaustive sweep of every stored state against every write value of the five-bit field.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int FIELD_W = 5;

  localparam int IDX_POR_CAUSE = 4;
  localparam int IDX_SOFT_POR  = 3;
  localparam int IDX_SOFT_XIR  = 2;
  localparam int IDX_BTN_POR   = 1;
  localparam int IDX_BTN_XIR   = 0;

  localparam logic [FIELD_W-1:0] CLR_MASK  = 5'b10011;
  localparam logic [FIELD_W-1:0] LOAD_MASK = 5'b01100;
  localparam logic [FIELD_W-1:0] POR_VALUE = 5'b10000;
endpackage

// File: rtl/rcs_arm_flag.sv
module rcs_arm_flag (
  input  logic clk,
  input  logic rst,
  input  logic pwr_on,
  output logic por_pending
);
  always_ff @(posedge clk) begin
    if (pwr_on)
      por_pending <= 1'b1;
    else if (rst)
      por_pending <= 1'b0;
  end

  assert_capture_once_R5: assert property (@(posedge clk) disable iff (pwr_on)
    rst |=> !por_pending);
endmodule

// File: rtl/rcs_cause_reg.sv
module rcs_cause_reg
  import rcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_on,
  input  logic               por_pending,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic               btn_por,
  input  logic               btn_xir,
  output logic [FIELD_W-1:0] field_q
);
  logic [FIELD_W-1:0] field_d;

  always_comb begin
    field_d = field_q;
    if (rst) begin
      if (por_pending)
        field_d = POR_VALUE;
    end else if (wr_en) begin
      field_d = field_d & ~(wr_field & CLR_MASK);
      field_d = (field_d & ~LOAD_MASK) | (wr_field & LOAD_MASK);
    end
    if (btn_por) field_d[IDX_BTN_POR] = 1'b1;
    if (btn_xir) field_d[IDX_BTN_XIR] = 1'b1;
  end

  always_ff @(posedge clk) field_q <= field_d;

  assert_clear_por_R2: assert property (@(posedge clk) disable iff (rst || pwr_on)
    wr_en && wr_field[IDX_POR_CAUSE] |=> !field_q[IDX_POR_CAUSE]);

  assert_direct_load_R3: assert property (@(posedge clk) disable iff (rst || pwr_on)
    wr_en |=> field_q[IDX_SOFT_POR:IDX_SOFT_XIR] == $past(wr_field[IDX_SOFT_POR:IDX_SOFT_XIR]));

  assert_first_load_R5: assert property (@(posedge clk) disable iff (pwr_on)
    rst && por_pending |=> field_q[IDX_POR_CAUSE] && !field_q[IDX_SOFT_POR] && !field_q[IDX_SOFT_XIR]);

  assert_later_reset_R6: assert property (@(posedge clk) disable iff (pwr_on)
    rst && !por_pending && !btn_por && !btn_xir |=> $stable(field_q));

  assert_button_wins_R7: assert property (@(posedge clk) disable iff (pwr_on)
    btn_por |=> field_q[IDX_BTN_POR]);
endmodule

// File: rtl/rcs_req_gen.sv
module rcs_req_gen (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic soft_por,
  input  logic soft_xir,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (rst)
      req_q <= 1'b0;
    else
      req_q <= wr_en && (soft_por || soft_xir);
  end

  assert_req_source_R4: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(wr_en) && ($past(soft_por) || $past(soft_xir)));

  assert_req_blocked_R8: assert property (@(posedge clk)
    rst |=> !req_q);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_on,
  input  logic              btn_por,
  input  logic              btn_xir,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_rst_req
);
  localparam int FIELD_LSB = DATA_W - FIELD_W;

  logic               por_pending;
  logic [FIELD_W-1:0] wr_field;
  logic [FIELD_W-1:0] field_q;
  logic               unused_low;

  assign wr_field   = wr_data[DATA_W-1:FIELD_LSB];
  assign unused_low = ^wr_data[FIELD_LSB-1:0];

  rcs_arm_flag u_arm (
    .clk         (clk),
    .rst         (rst),
    .pwr_on      (pwr_on),
    .por_pending (por_pending)
  );

  rcs_cause_reg u_cause (
    .clk         (clk),
    .rst         (rst),
    .pwr_on      (pwr_on),
    .por_pending (por_pending),
    .wr_en       (wr_en),
    .wr_field    (wr_field),
    .btn_por     (btn_por),
    .btn_xir     (btn_xir),
    .field_q     (field_q)
  );

  rcs_req_gen u_req (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .soft_por (wr_field[IDX_SOFT_POR]),
    .soft_xir (wr_field[IDX_SOFT_XIR]),
    .req_q    (sys_rst_req)
  );

  always_comb begin
    rd_data = '0;
    rd_data[DATA_W-1:FIELD_LSB] = field_q;
  end

  assert_write_ignored_R8: assert property (@(posedge clk) disable iff (pwr_on)
    rst && !por_pending && !btn_por && !btn_xir |=> $stable(rd_data));
endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_on = 1'b1;
  logic        btn_por = 1'b0;
  logic        btn_xir = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sys_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rst_cause_reg u_dut (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .btn_por(btn_por), .btn_xir(btn_xir),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sys_rst_req(sys_rst_req)
  );

  function automatic logic [31:0] fld(input logic [4:0] f);
    return {f, 27'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rst = 1'b0; pwr_on = 1'b0; wr_en = 1'b0; btn_por = 1'b0; btn_xir = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Put the field into state p: power-on, first reset, write, buttons.
  task automatic set_state(input logic [4:0] p);
    pwr_on = 1'b1; @(negedge clk); pwr_on = 1'b0;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    do_write(fld({~p[4], p[3], p[2], 2'b00}));
    btn_por = p[1]; btn_xir = p[0]; @(negedge clk);
    btn_por = 1'b0; btn_xir = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    pwr_on = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R5 reset state", rd_data, 32'h8000_0000);
    check("R4 no request after reset", {31'b0, sys_rst_req}, 32'h0);

    // Exhaustive sweep: every state against every write value.
    for (int s = 0; s < 32; s++) begin
      for (int w = 0; w < 32; w++) begin
        logic [4:0] p, wv, e;
        p = 5'(s); wv = 5'(w);
        set_state(p);
        check("R2 R3 state setup", rd_data, fld(p));
        e = p & ~(wv & 5'b10011);
        e[3:2] = wv[3:2];
        do_write(fld(wv) | (32'h05A5_A5A5 & 32'h07FF_FFFF) ^ 32'(w));
        check("R1 R2 R3 write result", rd_data, fld(e));
        check("R4 request pulse", {31'b0, sys_rst_req}, {31'b0, wv[3] | wv[2]});
        idle();
        check("R4 pulse ends", {31'b0, sys_rst_req}, 32'h0);
        check("R1 R2 R3 held", rd_data, fld(e));
      end
    end

    // R6: a later reset leaves the register alone.
    set_state(5'b01111);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R6 later reset", rd_data, 32'h7800_0000);
    check("R6 no pulse", {31'b0, sys_rst_req}, 32'h0);

    // R6 with a button active during the reset cycle.
    set_state(5'b00100);
    rst = 1'b1; btn_xir = 1'b1; @(negedge clk); rst = 1'b0; btn_xir = 1'b0;
    check("R6 R7 button during reset", rd_data, 32'h2800_0000);

    // R8: a write during reset is ignored.
    set_state(5'b00010);
    rst = 1'b1; wr_en = 1'b1; wr_data = 32'h7800_0000;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    check("R8 write in reset ignored", rd_data, 32'h1000_0000);
    check("R8 no pulse", {31'b0, sys_rst_req}, 32'h0);
    @(negedge clk);
    check("R8 still no pulse", {31'b0, sys_rst_req}, 32'h0);

    // R7: a button set wins over a write clear in the same cycle.
    set_state(5'b00011);
    btn_por = 1'b1; wr_en = 1'b1; wr_data = 32'h1800_0000;
    @(negedge clk);
    btn_por = 1'b0; wr_en = 1'b0;
    check("R7 btn_por beats clear", rd_data, 32'h1000_0000);
    btn_xir = 1'b1; wr_en = 1'b1; wr_data = 32'h1800_0000;
    @(negedge clk);
    btn_xir = 1'b0; wr_en = 1'b0;
    check("R7 btn_xir beats clear", rd_data, 32'h0800_0000);

    // R9: power-on alone keeps the value, then re-arms the capture.
    set_state(5'b01011);
    pwr_on = 1'b1; @(negedge clk); pwr_on = 1'b0;
    check("R9 pwr_on alone", rd_data, 32'h5800_0000);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R9 re-armed load", rd_data, 32'h8000_0000);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R9 R6 second reset keeps", rd_data, 32'h8000_0000);

    // R5: a button in the first reset cycle joins the power-on value.
    pwr_on = 1'b1; @(negedge clk); pwr_on = 1'b0;
    rst = 1'b1; btn_por = 1'b1; @(negedge clk); rst = 1'b0; btn_por = 1'b0;
    check("R5 first reset with button", rd_data, 32'h9000_0000);

    // R4: back-to-back requesting writes give back-to-back pulses.
    do_write(32'h6000_0000);
    check("R4 first pulse", {31'b0, sys_rst_req}, 32'h1);
    do_write(32'h2000_0000);
    check("R4 second pulse", {31'b0, sys_rst_req}, 32'h1);
    do_write(32'h0000_0000);
    check("R4 R3 zero write", {31'b0, sys_rst_req}, 32'h0);
    check("R3 zero write clears soft bits", rd_data, 32'h9000_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule